// File: doc/BRIEF.md
# Single-Cycle Bus I/O Request Controller

This block lets a local processor run one I/O read or one I/O write on a PCI-style bus. The processor does this through a small register window. Software loads a target address. For a write, it also loads the outgoing data word. It then writes a control word that carries active-low byte-lane enables and a direction bit. That control write is what launches the bus request. No separate start bit exists.

While the request is outstanding, the controller drives the following lines steadily:

- a request line,
- the address,
- the direction,
- the inverted-sense lane enables,
- the write data.

It holds them until the bus side returns a one-cycle completion strobe. For a read, the strobe also carries the returned word, which the controller stores in the data register.

Progress is reported through two status bits: Busy and Done. Done is cleared by writing a one to it. An interrupt-enable bit in the same status register gates Done onto an interrupt line. Software can therefore either poll Done or wait for the interrupt.

Top module: `iocyc_ctrl`

## Requirements
- R1: After reset, Busy, Done, the interrupt enable, `irq` and `bus_req` are 0, and the address, data and control registers read back as 0.
- R2: The register selects are 0 address, 1 data, 2 control, 3 status. A processor write to select 2 while Busy is 0 sets Busy at the next clock edge and asserts `bus_req`. While the request is held, the outputs follow the stored registers: `bus_addr` shows the address register, `bus_be_n` shows control bits [3:0], and `bus_rd` shows control bit 4, where 1 means read and 0 means write.
- R3: `bus_req` stays asserted until a clock edge at which `bus_done` is 1. At that same edge Busy clears and Done sets.
- R4: When a read request completes, the data register captures `bus_rdata` as sampled with `bus_done`.
- R5: During a write request, `bus_wdata` equals the data register. Completion of a write leaves the data register unchanged.
- R6: A processor write to the control register while Busy is 1 is ignored. The control register keeps its value, and no second request follows the completion.
- R7: The status register layout is bit 0 Busy (read only), bit 1 Done, and bit 2 interrupt enable (read/write). Writing 1 to bit 1 clears Done, and writing 0 to bit 1 leaves Done unchanged. If a completion and a clearing write occur at the same edge, Done ends up set.
- R8: `irq` is 1 exactly when Done and the interrupt enable are both 1, so clearing either bit removes the interrupt.
- R9: A `bus_done` pulse while Busy is 0 has no effect on Busy, Done or the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Processor register write strobe |
| reg_wsel | input | 2 | Register select for the write |
| reg_wdata | input | DATA_W | Processor write data |
| reg_rsel | input | 2 | Register select for read-back |
| reg_rdata | output | DATA_W | Read-back value of the selected register |
| bus_req | output | 1 | I/O request outstanding |
| bus_addr | output | ADDR_W | I/O address of the request |
| bus_rd | output | 1 | 1 read, 0 write |
| bus_be_n | output | DATA_W/8 | Active-low byte-lane enables, bit 0 = byte 0 |
| bus_wdata | output | DATA_W | Write data of the request |
| bus_done | input | 1 | One-cycle completion strobe |
| bus_rdata | input | DATA_W | Returned data, valid with `bus_done` |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the bus side produces `bus_done` only as a single-cycle pulse. They also assume that `bus_rdata` is meaningful only in that cycle, and that the processor holds its write strobe for exactly one cycle per access.

The stimulus stays within these limits. The responder raises `bus_done` for one clock after a random delay of zero to four cycles following the request. The processor tasks pulse `reg_wr` once per register access.

Outside those limits, a few pulses are deliberate:
- stray `bus_done` pulses while idle,
- control writes issued during a pending request,
- a completion coinciding with a Done-clearing write.

These exercise the ignore and priority rules.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   localparam int ST_BUSY = 0;
   localparam int ST_DONE = 1;
   localparam int ST_IE   = 2;
   localparam int ST_W    = 3;
endpackage

// File: rtl/iocyc_regs.sv
module iocyc_regs
   import iocyc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_wsel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              busy,
   input  logic              complete,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [BE_W-1:0]   be_n_q,
   output logic              rd_q
);
   logic wr_addr, wr_data, wr_ctrl;

   assign wr_addr = reg_wr && (reg_wsel == SEL_ADDR);
   assign wr_data = reg_wr && (reg_wsel == SEL_DATA);
   assign wr_ctrl = reg_wr && (reg_wsel == SEL_CTRL) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (wr_addr) begin
         addr_q <= reg_wdata[ADDR_W-1:0];
      end
   end

   // read return takes priority over a concurrent software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (complete && rd_q) begin
         data_q <= bus_rdata;
      end else if (wr_data) begin
         data_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_n_q <= '0;
         rd_q   <= 1'b0;
      end else if (wr_ctrl) begin
         be_n_q <= reg_wdata[BE_W-1:0];
         rd_q   <= reg_wdata[BE_W];
      end
   end

   assert_rd_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && rd_q) |=> (data_q == $past(bus_rdata)));

   assert_wr_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && !rd_q && !(reg_wr && reg_wsel == SEL_DATA)) |=> $stable(data_q));

   assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_wsel == SEL_CTRL) |=> ($stable(be_n_q) && $stable(rd_q)));
endmodule

// File: rtl/iocyc_status.sv
module iocyc_status
   import iocyc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [1:0]      reg_wsel,
   input  logic [ST_W-1:0] stat_wbits,
   input  logic            bus_done,
   output logic            busy_q,
   output logic            done_q,
   output logic            ie_q,
   output logic            complete
);
   logic start, wr_stat;

   assign start    = reg_wr && (reg_wsel == SEL_CTRL) && !busy_q;
   assign complete = busy_q && bus_done;
   assign wr_stat  = reg_wr && (reg_wsel == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
      end else if (complete) begin
         busy_q <= 1'b0;
      end
   end

   // completion beats a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (complete) begin
         done_q <= 1'b1;
      end else if (wr_stat && stat_wbits[ST_DONE]) begin
         done_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
      end else if (wr_stat) begin
         ie_q <= stat_wbits[ST_IE];
      end
   end

   assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && reg_wr && reg_wsel == SEL_CTRL) |=> busy_q);

   assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bus_done) |=> busy_q);

   assert_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bus_done) |=> (done_q && !busy_q));

   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && stat_wbits[ST_DONE] && !(busy_q && bus_done)) |=> !done_q);

   assert_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && bus_done && !reg_wr) |=> (!busy_q && $stable(done_q)));
endmodule

// File: rtl/iocyc_ctrl.sv
module iocyc_ctrl
   import iocyc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_wsel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [1:0]        reg_rsel,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic [BE_W-1:0]   bus_be_n,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int CTRL_W = BE_W + 1;

   if (DATA_W % 8 != 0) begin : g_chk_lanes
      $error("DATA_W must be a whole number of bytes");
   end
   if (ADDR_W > DATA_W) begin : g_chk_addr
      $error("ADDR_W must fit in one register word");
   end
   if (CTRL_W > DATA_W || ST_W > DATA_W) begin : g_chk_fields
      $error("control or status fields exceed the register word");
   end

   logic              busy, done, ie, complete;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [BE_W-1:0]   be_n_q;
   logic              rd_q;

   iocyc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_wsel  (reg_wsel),
      .reg_wdata (reg_wdata),
      .busy      (busy),
      .complete  (complete),
      .bus_rdata (bus_rdata),
      .addr_q    (addr_q),
      .data_q    (data_q),
      .be_n_q    (be_n_q),
      .rd_q      (rd_q)
   );

   iocyc_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_wsel   (reg_wsel),
      .stat_wbits (reg_wdata[ST_W-1:0]),
      .bus_done   (bus_done),
      .busy_q     (busy),
      .done_q     (done),
      .ie_q       (ie),
      .complete   (complete)
   );

   assign bus_req   = busy;
   assign bus_addr  = addr_q;
   assign bus_rd    = rd_q;
   assign bus_be_n  = be_n_q;
   assign bus_wdata = data_q;

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= done && ie;
      end
   end else begin : g_irq_comb
      assign irq = done && ie;

      assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (done && bus_req == busy));
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel_e'(reg_rsel))
         SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
         SEL_DATA: reg_rdata = data_q;
         SEL_CTRL: reg_rdata[CTRL_W-1:0] = {rd_q, be_n_q};
         SEL_STAT: begin
            reg_rdata[ST_BUSY] = busy;
            reg_rdata[ST_DONE] = done;
            reg_rdata[ST_IE]   = ie;
         end
         default: reg_rdata = '0;
      endcase
   end

   assert_req_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_done) |=> (bus_req && $stable(bus_rd) && $stable(bus_be_n)));
endmodule

// File: tb/tb_iocyc_ctrl.sv
module tb_iocyc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_wsel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_rsel = 2'd0;
   logic [31:0] reg_rdata;
   logic        bus_req, bus_rd, irq;
   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_be_n;
   logic        bus_done = 1'b0;
   logic [31:0] bus_rdata = '0;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   iocyc_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
      .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
      .bus_done(bus_done), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] exp_data(logic rd, logic [31:0] old, logic [31:0] ret);
      return rd ? ret : old;
   endfunction

   function automatic logic [31:0] exp_ctrl(logic rd, logic [3:0] be_n);
      return {27'd0, rd, be_n};
   endfunction

   function automatic logic [31:0] exp_stat(logic ie, logic done, logic busy);
      return {29'd0, ie, done, busy};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [1:0] sel, input logic [31:0] val);
      @(negedge clk);
      reg_wr = 1'b1; reg_wsel = sel; reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic cpu_rd(input logic [1:0] sel, output logic [31:0] val);
      reg_rsel = sel;
      #1 val = reg_rdata;
   endtask

   task automatic respond(input logic [31:0] ret);
      @(negedge clk);
      bus_done = 1'b1; bus_rdata = ret;
      @(negedge clk);
      bus_done = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      checks++; fails++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] data_model;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cpu_rd(2'd3, v); chk(v, exp_stat(0, 0, 0), "R1 status");
      cpu_rd(2'd0, v); chk(v, 32'd0, "R1 addr");
      cpu_rd(2'd1, v); chk(v, 32'd0, "R1 data");
      cpu_rd(2'd2, v); chk(v, 32'd0, "R1 ctrl");
      chk({31'd0, bus_req}, 32'd0, "R1 bus_req");
      chk({31'd0, irq}, 32'd0, "R1 irq");

      // directed write cycle, all lanes
      cpu_wr(2'd0, 32'h0000_1000);
      cpu_wr(2'd1, 32'hCAFE_BABE);
      cpu_wr(2'd2, exp_ctrl(1'b0, 4'h0));
      chk({31'd0, bus_req}, 32'd1, "R2 req");
      chk(bus_addr, 32'h0000_1000, "R2 addr");
      chk({31'd0, bus_rd}, 32'd0, "R2 dir");
      chk({28'd0, bus_be_n}, 32'd0, "R2 be_n");
      chk(bus_wdata, 32'hCAFE_BABE, "R5 wdata");
      cpu_wr(2'd2, exp_ctrl(1'b1, 4'hF));
      cpu_rd(2'd2, v); chk(v, exp_ctrl(1'b0, 4'h0), "R6 ctrl ignored");
      repeat (3) @(negedge clk);
      chk({31'd0, bus_req}, 32'd1, "R3 req held");
      respond(32'h1234_5678);
      cpu_rd(2'd3, v); chk(v, exp_stat(0, 1, 0), "R3 busy off done on");
      cpu_rd(2'd1, v); chk(v, 32'hCAFE_BABE, "R5 data kept");
      chk({31'd0, irq}, 32'd0, "R8 irq off when disabled");
      repeat (2) @(negedge clk);
      chk({31'd0, bus_req}, 32'd0, "R6 no second cycle");

      // R7 write-one-to-clear
      cpu_wr(2'd3, 32'h0);
      cpu_rd(2'd3, v); chk(v, exp_stat(0, 1, 0), "R7 zero keeps done");
      cpu_wr(2'd3, 32'h2);
      cpu_rd(2'd3, v); chk(v, exp_stat(0, 0, 0), "R7 one clears done");

      // read cycle with interrupt
      cpu_wr(2'd3, 32'h4);
      cpu_wr(2'd2, exp_ctrl(1'b1, 4'b1010));
      chk({28'd0, bus_be_n}, 32'h0000_000A, "R2 be_n lanes");
      chk({31'd0, bus_rd}, 32'd1, "R2 read dir");
      chk({31'd0, irq}, 32'd0, "R8 no irq while busy");
      respond(32'hDEAD_0042);
      cpu_rd(2'd1, v); chk(v, 32'hDEAD_0042, "R4 captured");
      chk({31'd0, irq}, 32'd1, "R8 irq raised");
      cpu_wr(2'd3, 32'h6);
      chk({31'd0, irq}, 32'd0, "R8 irq cleared");

      // R9 stray strobe while idle
      respond(32'hFFFF_FFFF);
      cpu_rd(2'd3, v); chk(v, exp_stat(1, 0, 0), "R9 status unchanged");
      cpu_rd(2'd1, v); chk(v, 32'hDEAD_0042, "R9 data unchanged");

      // R7 completion and clear in the same cycle
      cpu_wr(2'd2, exp_ctrl(1'b0, 4'h3));
      @(negedge clk);
      bus_done = 1'b1; reg_wr = 1'b1; reg_wsel = 2'd3; reg_wdata = 32'h6;
      @(negedge clk);
      bus_done = 1'b0; reg_wr = 1'b0;
      cpu_rd(2'd3, v); chk(v, exp_stat(1, 1, 0), "R7 set wins");
      cpu_wr(2'd3, 32'h6);

      // random cycles
      cpu_rd(2'd1, data_model);
      for (int i = 0; i < 24; i++) begin
         logic [31:0] a, d, ret;
         logic [3:0]  be;
         logic        rd;
         int          dly;
         a = $urandom; d = $urandom; ret = $urandom;
         be = 4'($urandom); rd = 1'($urandom); dly = $urandom % 5;
         cpu_wr(2'd0, a);
         cpu_wr(2'd1, d);
         data_model = d;
         cpu_wr(2'd2, exp_ctrl(rd, be));
         chk(bus_addr, a, "R2 rand addr");
         chk({28'd0, bus_be_n}, {28'd0, be}, "R2 rand be_n");
         chk({31'd0, bus_rd}, {31'd0, rd}, "R2 rand dir");
         if (!rd) chk(bus_wdata, d, "R5 rand wdata");
         repeat (dly) @(negedge clk);
         chk({31'd0, bus_req}, 32'd1, "R3 rand held");
         respond(ret);
         data_model = exp_data(rd, data_model, ret);
         cpu_rd(2'd1, v); chk(v, data_model, rd ? "R4 rand capture" : "R5 rand keep");
         cpu_rd(2'd3, v); chk(v, exp_stat(1, 1, 0), "R3 rand status");
         chk({31'd0, irq}, 32'd1, "R8 rand irq");
         cpu_wr(2'd3, 32'h6);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule